// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port Register Block

This block is the register front end of a general-purpose I/O port with sixteen pins. A simple register bus (write strobe, read strobe, word address, write data, registered read data) reaches two per-pin configuration registers, an output data word, an atomic set/clear word, a clear-only word, a read-only input status word and a per-pin extra-speed word. From this state the block drives, per pin, the output value, the output enable, the open-drain select and the pull-up and pull-down requests sent to the pad. Pin inputs are brought into the clock domain by a synchronizer before software can see them.

Each pin owns a 4-bit field. Pins in the lower half of the port sit in the low configuration register and pins in the upper half sit in the high one. A field's low two bits are its speed part: zero makes the pin an input and any other value makes it an output at one of three speed grades. The upper two bits are its mode part, read as an input flavour or an output flavour depending on the speed part. A lock mask from a neighbouring lock block freezes the fields of selected pins against later writes.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset both configuration registers read 0x44444444, so every pin is a floating input with speed part 00 and mode part 01. The output data register reads 0, all output enables are low and no pull is requested.
- R2: Pin p uses bits [4*(p%8)+3 : 4*(p%8)] of the configuration register at address 0 for p < 8 and of the one at address 1 for p >= 8. Bits [1:0] of the field are the speed part and bits [3:2] the mode part. A nonzero speed part raises pin_oe, and speed_grade[2p+1:2p] shows the speed part.
- R3: In output mode, mode bit 0 (field bit 2) set drives pin_od high (open-drain) and clear means push-pull. Mode bit 1 (field bit 3) selects alternate-function use; it is stored and read back but changes no output.
- R4: In input mode, mode part 00 is analog, 01 floating, 10 pulled and 11 reserved (treated as floating). A pulled pin raises pull_up when its output data bit is 1 and pull_dn when it is 0. Pulls are never requested for an output pin.
- R5: Address 3 holds the output data word. A write loads wdata[15:0] whole, a read returns it zero-extended, and pin_out follows it.
- R6: A write to address 4 sets the output data bits given in wdata[15:0] and clears those given in wdata[31:16], leaving all other bits unchanged. When both halves name the same bit, the set wins.
- R7: A write to address 5 clears the output data bits given in wdata[15:0]. wdata[31:16] is ignored and all other bits are unchanged.
- R8: Address 2 returns the pin inputs through a two-stage synchronizer. A pin change made just before clock edge k shows in a read that captures at edge k+2, and not in reads that capture at edge k or k+1. Writes to address 2 have no effect.
- R9: Address 6 holds the extra-speed word (wdata[15:0], readable). speed_boost[p] is high only when bit p of that word is set and pin p's speed part is 11.
- R10: A configuration write leaves the field of every pin whose lock_mask bit is high unchanged. The other fields in the same write are updated.
- R11: rdata is registered. It carries the addressed register in the cycle after a clock edge with rd_en high, and is 0 after any other edge. Reads of addresses 4, 5 and unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| lock_mask | input | 16 | Per-pin configuration lock from the lock block |
| pin_in | input | 16 | Asynchronous pad inputs |
| pin_out | output | 16 | Per-pin output value |
| pin_oe | output | 16 | Per-pin output enable |
| pin_od | output | 16 | Per-pin open-drain select |
| pull_up | output | 16 | Per-pin pull-up request |
| pull_dn | output | 16 | Per-pin pull-down request |
| speed_grade | output | 32 | Per-pin 2-bit speed part |
| speed_boost | output | 16 | Per-pin extra-speed active |

## Verification
The hardest case to reach from the ports is the same-bit conflict inside one atomic word, where a set and a clear name the same pin in a single write. The bench builds the write data with both halves overlapping on one bit and disjoint on another. The synchronizer latency is pinned down by changing pin_in and then issuing back-to-back reads, so the captures land exactly one, two and three edges after the change. Locked writes are checked by reading back a configuration word that mixes locked and unlocked lanes.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
   // word addresses of the register file
   localparam int unsigned REG_CFG_LO = 0;
   localparam int unsigned REG_CFG_HI = 1;
   localparam int unsigned REG_ISTAT  = 2;
   localparam int unsigned REG_ODATA  = 3;
   localparam int unsigned REG_BSET   = 4;
   localparam int unsigned REG_BCLR   = 5;
   localparam int unsigned REG_XSPD   = 6;

   // per-pin configuration field: mode part above speed part
   typedef struct packed {
      logic [1:0] mode;
      logic [1:0] speed;
   } pin_cfg_t;

   localparam int unsigned FIELD_W = $bits(pin_cfg_t);

   localparam logic [1:0] SPEED_INPUT = 2'b00;
   localparam logic [1:0] SPEED_TOP   = 2'b11;
   localparam logic [1:0] MODE_PULLED = 2'b10;

   localparam pin_cfg_t CFG_RESET_FIELD = '{mode: 2'b01, speed: 2'b00};
endpackage

// File: rtl/gpio_cfg_bank.sv
`timescale 1ns/1ps
module gpio_cfg_bank
   import gpio_port_pkg::*;
#(
   parameter int unsigned PINS   = 16,
   parameter int unsigned DATA_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              wr_sel,
   input  logic [DATA_W-1:0]       wdata,
   input  logic [PINS-1:0]         lock_mask,
   output logic [PINS*FIELD_W-1:0] cfg_flat
);
   localparam int unsigned HALF = PINS / 2;

   for (genvar p = 0; p < PINS; p++) begin : g_pin
      localparam int unsigned BANK = p / HALF;
      localparam int unsigned LANE = p % HALF;
      pin_cfg_t field_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            field_q <= CFG_RESET_FIELD;
         end else if (wr_sel[BANK] && !lock_mask[p]) begin
            field_q <= pin_cfg_t'(wdata[LANE*FIELD_W +: FIELD_W]);
         end
      end

      assign cfg_flat[p*FIELD_W +: FIELD_W] = field_q;
   end
endmodule

// File: rtl/gpio_out_data.sv
`timescale 1ns/1ps
module gpio_out_data #(
   parameter int unsigned PINS   = 16,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_word,
   input  logic              wr_set,
   input  logic              wr_clr,
   input  logic [DATA_W-1:0] wdata,
   output logic [PINS-1:0]   odata
);
   logic [PINS-1:0] set_mask;
   logic [PINS-1:0] clr_mask;
   logic [PINS-1:0] odata_d;

   always_comb begin
      set_mask = wr_set ? wdata[PINS-1:0] : '0;
      clr_mask = '0;
      if (wr_set) clr_mask = clr_mask | wdata[2*PINS-1:PINS];
      if (wr_clr) clr_mask = clr_mask | wdata[PINS-1:0];
      // the set mask is applied after the clear so it wins on overlap
      if (wr_word) odata_d = wdata[PINS-1:0];
      else         odata_d = (odata & ~clr_mask) | set_mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) odata <= '0;
      else        odata <= odata_d;
   end
endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_decode.sv
`timescale 1ns/1ps
module gpio_pin_decode
   import gpio_port_pkg::*;
#(
   parameter int unsigned PINS = 16
) (
   input  logic [PINS*FIELD_W-1:0] cfg_flat,
   input  logic [PINS-1:0]         odata,
   input  logic [PINS-1:0]         xspeed,
   output logic [PINS-1:0]         pin_oe,
   output logic [PINS-1:0]         pin_od,
   output logic [PINS-1:0]         pull_up,
   output logic [PINS-1:0]         pull_dn,
   output logic [2*PINS-1:0]       speed_grade,
   output logic [PINS-1:0]         speed_boost
);
   for (genvar p = 0; p < PINS; p++) begin : g_pin
      pin_cfg_t f;
      logic     is_out;
      logic     pulled;

      assign f      = pin_cfg_t'(cfg_flat[p*FIELD_W +: FIELD_W]);
      assign is_out = (f.speed != SPEED_INPUT);
      assign pulled = !is_out && (f.mode == MODE_PULLED);

      assign pin_oe[p]             = is_out;
      assign pin_od[p]             = is_out && f.mode[0];
      assign pull_up[p]            = pulled && odata[p];
      assign pull_dn[p]            = pulled && !odata[p];
      assign speed_grade[2*p +: 2] = f.speed;
      assign speed_boost[p]        = xspeed[p] && (f.speed == SPEED_TOP);
   end
endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned PINS        = 16,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [PINS-1:0]   lock_mask,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_oe,
   output logic [PINS-1:0]   pin_od,
   output logic [PINS-1:0]   pull_up,
   output logic [PINS-1:0]   pull_dn,
   output logic [2*PINS-1:0] speed_grade,
   output logic [PINS-1:0]   speed_boost
);
   localparam int unsigned HALF   = PINS / 2;
   localparam int unsigned BANK_W = HALF * FIELD_W;

   // elaboration-time parameter checks
   if (PINS % 2 != 0) begin : g_err_odd
      $error("gpio_port_regs: PINS must be even");
   end
   if (BANK_W > DATA_W) begin : g_err_bank
      $error("gpio_port_regs: configuration bank wider than data bus");
   end
   if (2 * PINS > DATA_W) begin : g_err_set
      $error("gpio_port_regs: set/clear word needs 2*PINS data bits");
   end
   if (SYNC_STAGES < 2) begin : g_err_sync
      $error("gpio_port_regs: at least two synchronizer stages required");
   end
   if (ADDR_W < 3) begin : g_err_addr
      $error("gpio_port_regs: address too narrow for register map");
   end

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned reg_no);
      return a == ADDR_W'(reg_no);
   endfunction

   logic [1:0]              wr_cfg;
   logic                    wr_odata, wr_bset, wr_bclr, wr_xspd;
   logic [PINS*FIELD_W-1:0] cfg_flat;
   logic [PINS-1:0]         odata;
   logic [PINS-1:0]         istat;
   logic [PINS-1:0]         xspeed_q;
   logic [DATA_W-1:0]       rd_mux;

   assign wr_cfg[0] = wr_en && hit(addr, REG_CFG_LO);
   assign wr_cfg[1] = wr_en && hit(addr, REG_CFG_HI);
   assign wr_odata  = wr_en && hit(addr, REG_ODATA);
   assign wr_bset   = wr_en && hit(addr, REG_BSET);
   assign wr_bclr   = wr_en && hit(addr, REG_BCLR);
   assign wr_xspd   = wr_en && hit(addr, REG_XSPD);

   gpio_cfg_bank #(.PINS(PINS), .DATA_W(DATA_W)) i_cfg_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_sel    (wr_cfg),
      .wdata     (wdata),
      .lock_mask (lock_mask),
      .cfg_flat  (cfg_flat)
   );

   gpio_out_data #(.PINS(PINS), .DATA_W(DATA_W)) i_out_data (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_word (wr_odata),
      .wr_set  (wr_bset),
      .wr_clr  (wr_bclr),
      .wdata   (wdata),
      .odata   (odata)
   );

   gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) i_in_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (istat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       xspeed_q <= '0;
      else if (wr_xspd) xspeed_q <= wdata[PINS-1:0];
   end

   gpio_pin_decode #(.PINS(PINS)) i_pin_decode (
      .cfg_flat    (cfg_flat),
      .odata       (odata),
      .xspeed      (xspeed_q),
      .pin_oe      (pin_oe),
      .pin_od      (pin_od),
      .pull_up     (pull_up),
      .pull_dn     (pull_dn),
      .speed_grade (speed_grade),
      .speed_boost (speed_boost)
   );

   assign pin_out = odata;

   always_comb begin
      rd_mux = '0;
      if (hit(addr, REG_CFG_LO))      rd_mux[BANK_W-1:0] = cfg_flat[BANK_W-1:0];
      else if (hit(addr, REG_CFG_HI)) rd_mux[BANK_W-1:0] = cfg_flat[PINS*FIELD_W-1 -: BANK_W];
      else if (hit(addr, REG_ISTAT))  rd_mux[PINS-1:0]   = istat;
      else if (hit(addr, REG_ODATA))  rd_mux[PINS-1:0]   = odata;
      else if (hit(addr, REG_XSPD))   rd_mux[PINS-1:0]   = xspeed_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
      else            rdata <= '0;
   end
endmodule

// File: rtl/gpio_port_regs_chk.sv
`timescale 1ns/1ps
module gpio_port_regs_chk
   import gpio_port_pkg::*;
#(
   parameter int unsigned PINS   = 16,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [PINS-1:0]   wdata_lo,
   input logic [DATA_W-1:0] rdata,
   input logic [PINS-1:0]   lock_mask,
   input logic [PINS-1:0]   pin_in,
   input logic [PINS-1:0]   pin_out,
   input logic [PINS-1:0]   pin_oe,
   input logic [PINS-1:0]   pin_od,
   input logic [PINS-1:0]   pull_up,
   input logic [PINS-1:0]   pull_dn
);
   logic [2:0] since_rst;
   always_ff @(posedge clk) begin
      if (!rst_n)              since_rst <= '0;
      else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
   end

   logic out_write;
   assign out_write = wr_en && (addr == ADDR_W'(REG_ODATA) || addr == ADDR_W'(REG_BSET) ||
                                addr == ADDR_W'(REG_BCLR));

   // R6: every bit named in the set half is high afterwards
   p_set_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(REG_BSET)) |=> ((pin_out & $past(wdata_lo)) == $past(wdata_lo)));

   // R7: every bit named in the clear word is low afterwards
   p_clr_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(REG_BCLR)) |=> ((pin_out & $past(wdata_lo)) == '0));

   // R5: output data only moves on a data-word access
   p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !out_write |=> $stable(pin_out));

   // R4: pull-up and pull-down never together, never on an output pin
   p_pull_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((pull_up & pull_dn) == '0) && (((pull_up | pull_dn) & pin_oe) == '0));

   // R3: open-drain only on an enabled output
   p_od_needs_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_od & ~pin_oe) == '0);

   // R10: output enables of locked pins survive any write
   p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (((pin_oe ^ $past(pin_oe)) & $past(lock_mask)) == '0));

   // R8: status read shows the input from two edges before the capture
   p_istat_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(REG_ISTAT) && since_rst >= 3'd4)
         |=> (rdata[PINS-1:0] == $past(pin_in, 3)));

   // R11: read data returns to zero when no read was captured
   p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rdata == '0));
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.PINS(PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .addr      (addr),
   .wdata_lo  (wdata[PINS-1:0]),
   .rdata     (rdata),
   .lock_mask (lock_mask),
   .pin_in    (pin_in),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .pin_od    (pin_od),
   .pull_up   (pull_up),
   .pull_dn   (pull_dn)
);

// File: tb/test_gpio_port_regs.sv
`timescale 1ns/1ps
module test_gpio_port_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [15:0] lock_mask = '0;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out, pin_oe, pin_od, pull_up, pull_dn, speed_boost;
   logic [31:0] speed_grade;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   gpio_port_regs i_gpio_port_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .lock_mask(lock_mask), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od), .pull_up(pull_up),
      .pull_dn(pull_dn), .speed_grade(speed_grade), .speed_boost(speed_boost)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // all bus tasks start and end at a falling edge
   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      @(posedge clk); @(negedge clk);
      d = rdata;
      rd_en = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
      chk("R1 pulls", {pull_up, pull_dn}, 32'h0);
      chk("R1 pin_out", {16'h0, pin_out}, 32'h0);
      bus_read(4'd0, d); chk("R1 cfg low", d, 32'h4444_4444);
      bus_read(4'd1, d); chk("R1 cfg high", d, 32'h4444_4444);
      bus_read(4'd3, d); chk("R1 odata", d, 32'h0);
   endtask

   task automatic t_layout();
      logic [31:0] d;
      // pin0 push-pull grade 01, pin3 open-drain grade 11, pin7 AF open-drain grade 10
      bus_write(4'd0, 32'hE444_7441);
      chk("R2 oe low bank", {24'h0, pin_oe[7:0]}, 32'h89);
      chk("R2 speed_grade", {16'h0, speed_grade[15:0]}, 32'h80C1);
      chk("R3 open-drain", {24'h0, pin_od[7:0]}, 32'h88);
      bus_read(4'd0, d); chk("R3 AF bit stored", d, 32'hE444_7441);
      bus_write(4'd1, 32'h4442_4444);
      chk("R2 oe high bank", {24'h0, pin_oe[15:8]}, 32'h10);
      chk("R2 pin12 grade", {30'h0, speed_grade[25:24]}, 32'h2);
   endtask

   task automatic t_pull();
      // pins 8,9 pulled, 10 analog, 11 reserved
      bus_write(4'd1, 32'h4444_C088);
      bus_write(4'd3, 32'h0000_0100);
      chk("R4 pull_up", {24'h0, pull_up[15:8]}, 32'h01);
      chk("R4 pull_dn", {24'h0, pull_dn[15:8]}, 32'h02);
      chk("R4 no oe", {24'h0, pin_oe[15:8]}, 32'h0);
      bus_write(4'd4, 32'h0000_0A00);
      chk("R4 pull_up after set", {24'h0, pull_up[15:8]}, 32'h03);
      chk("R4 pull_dn after set", {24'h0, pull_dn[15:8]}, 32'h0);
   endtask

   task automatic t_odata();
      logic [31:0] d;
      bus_write(4'd3, 32'hFFFF_A5C3);
      chk("R5 pin_out", {16'h0, pin_out}, 32'hA5C3);
      bus_read(4'd3, d); chk("R5 readback", d, 32'h0000_A5C3);
   endtask

   task automatic t_setclr();
      bus_write(4'd3, 32'h0000_00F0);
      bus_write(4'd4, 32'h0000_0003);
      chk("R6 set", {16'h0, pin_out}, 32'h00F3);
      bus_write(4'd5, 32'h0000_0030);
      chk("R7 clear", {16'h0, pin_out}, 32'h00C3);
      bus_write(4'd4, 32'h00C0_0100);
      chk("R6 set and clear halves", {16'h0, pin_out}, 32'h0103);
      bus_write(4'd4, 32'h0003_0001);
      chk("R6 set wins", {16'h0, pin_out}, 32'h0101);
      bus_write(4'd5, 32'hFFFF_0000);
      chk("R7 upper half ignored", {16'h0, pin_out}, 32'h0101);
   endtask

   task automatic t_istat();
      logic [31:0] d;
      pin_in = 16'h1234;
      bus_read(4'd2, d); chk("R8 first edge", d, 32'h0);
      bus_read(4'd2, d); chk("R8 second edge", d, 32'h0);
      bus_read(4'd2, d); chk("R8 third edge", d, 32'h0000_1234);
      bus_write(4'd2, 32'h0000_FFFF);
      bus_read(4'd2, d); chk("R8 write ignored", d, 32'h0000_1234);
   endtask

   task automatic t_xspeed();
      logic [31:0] d;
      bus_write(4'd0, 32'h4444_4423);
      bus_write(4'd6, 32'h0000_0003);
      chk("R9 boost", {16'h0, speed_boost}, 32'h0001);
      bus_read(4'd6, d); chk("R9 readback", d, 32'h0000_0003);
   endtask

   task automatic t_lock();
      logic [31:0] d;
      lock_mask = 16'h00F0;
      bus_write(4'd0, 32'h1111_1111);
      bus_read(4'd0, d); chk("R10 locked lanes kept", d, 32'h4444_1111);
      chk("R10 locked oe", {28'h0, pin_oe[7:4]}, 32'h0);
      lock_mask = 16'h0000;
      bus_write(4'd0, 32'h1111_1111);
      bus_read(4'd0, d); chk("R10 unlocked write", d, 32'h1111_1111);
   endtask

   task automatic t_read();
      logic [31:0] d;
      bus_write(4'd3, 32'h0000_FFFF);
      chk("R11 idle rdata", rdata, 32'h0);
      bus_read(4'd4, d); chk("R11 set word reads 0", d, 32'h0);
      bus_read(4'd5, d); chk("R11 clear word reads 0", d, 32'h0);
      bus_read(4'd15, d); chk("R11 unmapped reads 0", d, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_layout();
      t_pull();
      t_odata();
      t_setclr();
      t_istat();
      t_xspeed();
      t_lock();
      t_read();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements) actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule